// File: doc/BRIEF.md
# Dual-Direction Transition Counter

This block watches one synchronous input line and keeps two running tallies of its transitions: one counts low-to-high changes, the other counts high-to-low changes. The previous sample of the line is held in a flip-flop. Each clock cycle the block compares the present level with that stored sample to decide whether a transition occurred, and if so which way it went.

Both tallies are unsigned and 16 bits wide by default. Each wraps silently to zero after its maximum value. They are presented on the outputs continuously, so a consumer can read them in any cycle without a request. The monitored line must already be synchronous to the clock. A synchronous, active-low reset clears both tallies. The same reset captures the present line level, so a level that is steady across reset release is not counted.

Top module: `edge_tally`

## Requirements
- R1: When `sig_in` is 1 in a cycle and was 0 at the previous clock edge, `rise_cnt` increases by exactly one on the next clock edge. The new value is visible on the port right after that edge.
- R2: When `sig_in` is 0 in a cycle and was 1 at the previous clock edge, `fall_cnt` increases by exactly one on the next clock edge. The new value is visible on the port right after that edge.
- R3: A clock edge with `rst_n` = 0 sets both counts to 0 and stores the current level of `sig_in` as the previous sample. If the level after reset release equals the level held during reset, no count moves.
- R4: When `rise_cnt` is 65535 and a low-to-high transition is seen, `rise_cnt` becomes 0 and `fall_cnt` keeps its value.
- R5: When `fall_cnt` is 65535 and a high-to-low transition is seen, `fall_cnt` becomes 0 and `rise_cnt` keeps its value.
- R6: In any clock cycle, at most one of the two counts changes.
- R7: While `sig_in` holds a constant level, neither count changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sig_in | input | 1 | Monitored line, already synchronous to `clk` |
| rise_cnt | output | 16 | Number of low-to-high transitions, modulo 65536 |
| fall_cnt | output | 16 | Number of high-to-low transitions, modulo 65536 |

## Verification
A wrong stored previous sample shows up at the ports within one clock edge. It either produces a count step while the line is steady or misses a step on a real transition, so every cycle of the stimulus table compares both counts against tallies that the bench predicts. A counter that fails to wrap, or that disturbs its neighbour at the wrap, becomes visible on the single edge where the maximum is passed. For that reason the bench drives the line through a full cycle of both counters and checks the values on each side of both wrap points. Reset faults appear on the first edge after release, where both counts must read zero and stay there while the held level is unchanged.

// File: rtl/edge_tally_pkg.sv
// Shared constants for the transition counter: indices of the two
// count directions and the number of directions.
package edge_tally_pkg;
    localparam int DIR_RISE = 0;
    localparam int DIR_FALL = 1;
    localparam int NUM_DIR  = 2;
endpackage

// File: rtl/edge_tally_detect.sv
// Transition detector. Keeps the previous sample of the monitored line
// and flags a low-to-high or high-to-low change for the current cycle.
// Assumes sig_in is synchronous to clk. During reset the stored sample
// follows the line, so no spurious flag follows reset release.
module edge_tally_detect
    import edge_tally_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sig_in,
    output logic [NUM_DIR-1:0] evt
);
    logic prev_q;

    // Store the line level seen at every edge, reset included.
    always_ff @(posedge clk) begin
        prev_q <= sig_in;
    end

    // Decode direction of change between stored and present level.
    always_comb begin
        evt           = '0;
        evt[DIR_RISE] = rst_n & sig_in & ~prev_q;
        evt[DIR_FALL] = rst_n & ~sig_in & prev_q;
    end
endmodule

// File: rtl/edge_tally_counter.sv
// Wrap-around event counter. Adds one on each edge where inc is high;
// the sum rolls from all-ones to zero. Synchronous active-low reset.
module edge_tally_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] STEP = CNT_W'(1);

    // Clear on reset, otherwise advance modulo 2**CNT_W on inc.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (inc) begin
            count <= count + STEP;
        end
    end
endmodule

// File: rtl/edge_tally.sv
// Dual-direction transition counter top. One detector feeds one
// wrap-around counter per direction; both counts drive the outputs
// continuously. Assumes sig_in is already synchronous to clk.
module edge_tally
    import edge_tally_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sig_in,
    output logic [CNT_W-1:0] rise_cnt,
    output logic [CNT_W-1:0] fall_cnt
);
    logic [NUM_DIR-1:0] evt;
    logic [CNT_W-1:0]   cnt_arr [NUM_DIR];

    edge_tally_detect u_detect (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_in (sig_in),
        .evt    (evt)
    );

    // One counter per transition direction.
    for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
        edge_tally_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (evt[d]),
            .count (cnt_arr[d])
        );
    end

    assign rise_cnt = cnt_arr[DIR_RISE];
    assign fall_cnt = cnt_arr[DIR_FALL];
endmodule

// File: rtl/edge_tally_chk.sv
// Property checker for edge_tally, attached by bind. It keeps its own
// copy of the last line level and reset level to form the expectations.
module edge_tally_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sig_in,
    input logic [CNT_W-1:0] rise_cnt,
    input logic [CNT_W-1:0] fall_cnt
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic in_q    = 1'b0;
    logic run_q   = 1'b0;
    logic valid_q = 1'b0;

    // Track the previous line level, the previous reset level and whether one edge has passed.
    always_ff @(posedge clk) begin
        in_q    <= sig_in;
        run_q   <= rst_n;
        valid_q <= 1'b1;
    end

    AST_RISE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && sig_in && !in_q) |=> (rise_cnt == $past(rise_cnt) + ONE)); // R1

    AST_FALL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && !sig_in && in_q) |=> (fall_cnt == $past(fall_cnt) + ONE)); // R2

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && !run_q) |-> (rise_cnt == '0 && fall_cnt == '0)); // R3

    AST_RISE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && sig_in && !in_q && (&rise_cnt)) |=> (rise_cnt == '0 && $stable(fall_cnt))); // R4

    AST_FALL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && !sig_in && in_q && (&fall_cnt)) |=> (fall_cnt == '0 && $stable(rise_cnt))); // R5

    AST_ONE_MOVER: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |=> !((rise_cnt != $past(rise_cnt)) && (fall_cnt != $past(fall_cnt)))); // R6

    AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && (sig_in == in_q)) |=> ($stable(rise_cnt) && $stable(fall_cnt))); // R7
endmodule

bind edge_tally edge_tally_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sig_in   (sig_in),
    .rise_cnt (rise_cnt),
    .fall_cnt (fall_cnt)
);

// File: tb/sim_edge_tally.sv
// Bench for edge_tally: a vector table, then reset and wrap tests.
module sim_edge_tally;
    localparam int NV = 12;
    // Each entry: {line level, expected rise count, expected fall count}
    localparam logic [32:0] VEC [NV] = '{
        {1'b1, 16'd0, 16'd0},   // R7 steady high after reset
        {1'b0, 16'd0, 16'd1},   // R2
        {1'b0, 16'd0, 16'd1},   // R7
        {1'b1, 16'd1, 16'd1},   // R1
        {1'b0, 16'd1, 16'd2},   // R2
        {1'b1, 16'd2, 16'd2},   // R1
        {1'b1, 16'd2, 16'd2},   // R7
        {1'b1, 16'd2, 16'd2},   // R7
        {1'b0, 16'd2, 16'd3},   // R2
        {1'b1, 16'd3, 16'd3},   // R1
        {1'b0, 16'd3, 16'd4},   // R2
        {1'b0, 16'd3, 16'd4}    // R7
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sig_in = 1'b1;
    logic [15:0] rise_cnt, fall_cnt;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    edge_tally u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .sig_in   (sig_in),
        .rise_cnt (rise_cnt),
        .fall_cnt (fall_cnt)
    );

    task automatic chk(input string tag, input logic [15:0] er, input logic [15:0] ef);
        checks++;
        if (rise_cnt !== er || fall_cnt !== ef) begin
            failures++;
            $display("FAIL %s rise=%0d exp %0d fall=%0d exp %0d", tag, rise_cnt, er, fall_cnt, ef);
        end
    endtask

    task automatic step(input logic v);
        @(negedge clk) sig_in = v;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R3 in reset", 16'd0, 16'd0);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk("R3 release with held level", 16'd0, 16'd0);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][32]);
            chk("R1/R2/R7 table", VEC[i][31:16], VEC[i][15:0]);
        end

        // Drive the rise count to 65535; the fall count wraps on the way.
        for (int i = 0; i < 65532; i++) begin
            step(1'b1);
            if (i == 65531) chk("R5 fall at max", 16'd65535, 16'd65535);
            step(1'b0);
        end
        chk("R5 fall wrapped, rise kept", 16'd65535, 16'd0);
        step(1'b1);
        chk("R4 rise wrapped, fall kept", 16'd0, 16'd0);
        step(1'b0);
        chk("R6 only fall moves", 16'd0, 16'd1);

        // Reset while the line changes; release with the level held.
        @(negedge clk) begin rst_n = 1'b0; sig_in = 1'b0; end
        @(posedge clk);
        @(negedge clk) sig_in = 1'b1;
        @(posedge clk);
        #1;
        chk("R3 cleared", 16'd0, 16'd0);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk("R3 no false rise", 16'd0, 16'd0);
        step(1'b1);
        chk("R7 steady", 16'd0, 16'd0);
        step(1'b0);
        chk("R2 after reset", 16'd0, 16'd1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule